// File: doc/BRIEF.md
# Clock and Supply Mode Sequencer

This controller moves a processor's system clock between a slow oscillator that always runs and a fast oscillator that can be gated off. It drives three control outputs: the core-supply mode select, the fast-oscillator enable and the clock-select line of an external glitch-free multiplexer. Software asks for fast or slow operation with single-cycle request pulses. The controller then steps through the required order and settle delays. It refuses requests that are not allowed and keeps a sticky error record that software clears.

Both settle delays are counted in ticks of a slow reference clock, which arrives as a one-cycle pulse. The tick counts are parameters. Their defaults assume a 32768 Hz reference: 82 ticks cover the supply settle of at least 2.5 ms and 164 ticks cover the oscillator start-up of at least 5 ms. Going up, the supply is raised first, then the oscillator is started, then the clock select is switched. Going down, the same steps run in reverse order, one cycle apart. A halt request from the processor is passed on only while the block sits idle on the slow clock.

Top module: `clk_mode_seq`

## Requirements
- R1: After a synchronous reset, all outputs are 0: `supply_hs`, `fast_osc_en`, `clk_sel_fast`, `busy`, `err_status`, `halt_out` and `halt_blocked`.
- R2: A fast request is accepted when it arrives alone, while idle on the slow clock, with `halver_mode` low. `supply_hs` and `busy` rise in the next cycle. `fast_osc_en` stays low until UP_SUPPLY_TICKS reference ticks have arrived after acceptance, and rises on the edge that samples the last of them.
- R3: `clk_sel_fast` rises on the edge that samples the OSC_SETTLE_TICKS-th tick counted from the rise of `fast_osc_en`. `busy` falls on that same edge.
- R4: An accepted slow request (one arriving alone while idle on the fast clock) lowers `clk_sel_fast` in the next cycle. `fast_osc_en` falls exactly one cycle after that, never on the same edge.
- R5: `supply_hs` falls one cycle after `fast_osc_en` falls. `busy` falls on that same edge. `supply_hs` is never low while `fast_osc_en` or `clk_sel_fast` is high.
- R6: A fast request made while idle on the slow clock with `halver_mode` high is refused. The block stays on the slow clock with `supply_hs` low, and error bit 1 (`err_status[1]`) is set.
- R7: `halt_out` is `halt_req` registered for one cycle, and it passes only when the sequencer was idle on the slow clock. In every other state `halt_out` stays 0 and `halt_blocked` carries the registered request instead.
- R8: `busy` is high in every cycle from the one after acceptance until the final step of the sequence, and low while idle.
- R9: While busy, any request is ignored and sets error bit 0 (`err_status[0]`). A fast and a slow request in the same cycle are also ignored and set bit 0.
- R10: Error bits are sticky. Writing 1 to bit i of `err_clr` clears `err_status[i]` on the next edge. When a set and a clear of the same bit coincide, the set wins.
- R11: A request for the mode already active changes no output and sets no error.
- R12: Ticks are counted only during the two settle waits. With no ticks, a wait holds its state for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle pulse per slow reference clock period |
| req_fast | input | 1 | Request pulse to move to the fast clock |
| req_slow | input | 1 | Request pulse to move to the slow clock |
| halver_mode | input | 1 | Low-speed regulator is in halver mode; the fast clock is forbidden |
| halt_req | input | 1 | Halt request from the processor |
| err_clr | input | 2 | Write 1 to clear the matching error bit |
| supply_hs | output | 1 | 1 selects the high-speed core supply and keeps its regulator enabled |
| fast_osc_en | output | 1 | Enables the fast oscillator |
| clk_sel_fast | output | 1 | Clock-select line to the multiplexer; 1 selects the fast oscillator |
| busy | output | 1 | A transition is in progress |
| err_status | output | 2 | Bit 0: request while busy or conflicting requests; bit 1: fast request refused in halver mode |
| halt_out | output | 1 | Halt passed on to the processor |
| halt_blocked | output | 1 | Halt request was withheld |

## Verification
The bench counts the reference ticks between each control edge of an up-sequence. A counter that is off by one would switch the oscillator or the clock select one tick early or late. It stops the ticks in the middle of a wait, which exposes a timer that advances on the system clock. It steps down the clock select, the oscillator and the supply one at a time and samples each cycle, so a design that merges two of those steps onto one edge fails. It also sends a request while busy with the matching clear bit raised in the same cycle, sends conflicting request pairs, and sends halt and fast requests under halver mode. These catch a lost sticky bit, a clear that wins over a set, and a fast request leaking through a forbidden state.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

    typedef enum logic [2:0] {
        ST_SLOW       = 3'd0,
        ST_UP_SUPPLY  = 3'd1,
        ST_UP_SETTLE  = 3'd2,
        ST_FAST       = 3'd3,
        ST_DN_SEL     = 3'd4,
        ST_DN_OSC     = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_GO_FAST = 2'd1,
        CMD_GO_SLOW = 2'd2
    } seq_cmd_e;

    localparam int ERR_W       = 2;
    localparam int ERR_OVERLAP = 0;
    localparam int ERR_REFUSED = 1;

    typedef struct packed {
        seq_cmd_e cmd;
        logic     overlap;
        logic     refused;
    } req_dec_t;

    typedef struct packed {
        logic supply_hs;
        logic osc_en;
        logic sel_fast;
        logic busy;
    } drive_t;

    function automatic drive_t drive_of(seq_state_e st);
        drive_t d;
        d = '0;
        unique case (st)
            ST_SLOW:      d = '{supply_hs: 1'b0, osc_en: 1'b0, sel_fast: 1'b0, busy: 1'b0};
            ST_UP_SUPPLY: d = '{supply_hs: 1'b1, osc_en: 1'b0, sel_fast: 1'b0, busy: 1'b1};
            ST_UP_SETTLE: d = '{supply_hs: 1'b1, osc_en: 1'b1, sel_fast: 1'b0, busy: 1'b1};
            ST_FAST:      d = '{supply_hs: 1'b1, osc_en: 1'b1, sel_fast: 1'b1, busy: 1'b0};
            ST_DN_SEL:    d = '{supply_hs: 1'b1, osc_en: 1'b1, sel_fast: 1'b0, busy: 1'b1};
            ST_DN_OSC:    d = '{supply_hs: 1'b1, osc_en: 1'b0, sel_fast: 1'b0, busy: 1'b1};
            default:      d = '0;
        endcase
        return d;
    endfunction

    function automatic logic is_idle(seq_state_e st);
        return (st == ST_SLOW) || (st == ST_FAST);
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cms_req_decode.sv
module cms_req_decode
    import clk_mode_pkg::*;
(
    input  seq_state_e state,
    input  logic       req_fast,
    input  logic       req_slow,
    input  logic       halver_mode,
    output req_dec_t   dec
);
    always_comb begin
        dec = '{cmd: CMD_NONE, overlap: 1'b0, refused: 1'b0};
        if (!is_idle(state)) begin
            dec.overlap = req_fast | req_slow;
        end else if (req_fast && req_slow) begin
            dec.overlap = 1'b1;
        end else if (state == ST_SLOW && req_fast) begin
            if (halver_mode) dec.refused = 1'b1;
            else             dec.cmd     = CMD_GO_FAST;
        end else if (state == ST_FAST && req_slow) begin
            dec.cmd = CMD_GO_SLOW;
        end
    end
endmodule

// File: rtl/cms_settle_timer.sv
module cms_settle_timer #(
    parameter int MAX_TICKS = 164,
    localparam int CNT_W    = $clog2(MAX_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + 1'b1;
    assign done    = run && tick && (cnt_nxt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || done) cnt_q <= '0;
        else if (tick)           cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/cms_halt_gate.sv
module cms_halt_gate (
    input  logic clk,
    input  logic rst,
    input  logic halt_req,
    input  logic slow_idle,
    output logic halt_out,
    output logic halt_blocked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_out     <= 1'b0;
            halt_blocked <= 1'b0;
        end else begin
            halt_out     <= halt_req &&  slow_idle;
            halt_blocked <= halt_req && !slow_idle;
        end
    end
endmodule

// File: rtl/cms_err_reg.sv
module cms_err_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= set[i] | (q[i] & ~clr[i]);
        end
    end
endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
    import clk_mode_pkg::*;
#(
    parameter int UP_SUPPLY_TICKS  = 82,
    parameter int OSC_SETTLE_TICKS = 164
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             req_fast,
    input  logic             req_slow,
    input  logic             halver_mode,
    input  logic             halt_req,
    input  logic [ERR_W-1:0] err_clr,
    output logic             supply_hs,
    output logic             fast_osc_en,
    output logic             clk_sel_fast,
    output logic             busy,
    output logic [ERR_W-1:0] err_status,
    output logic             halt_out,
    output logic             halt_blocked
);
    localparam int MAX_TICKS = max_of(max_of(UP_SUPPLY_TICKS, OSC_SETTLE_TICKS), 1);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] LIM_SUPPLY = CNT_W'(UP_SUPPLY_TICKS);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(OSC_SETTLE_TICKS);

    seq_state_e       state_q, state_d;
    req_dec_t         dec;
    drive_t           drv;
    logic             wait_run;
    logic             wait_done;
    logic [CNT_W-1:0] wait_limit;
    logic [ERR_W-1:0] err_set;

    cms_req_decode u_dec (
        .state       (state_q),
        .req_fast    (req_fast),
        .req_slow    (req_slow),
        .halver_mode (halver_mode),
        .dec         (dec)
    );

    assign wait_run   = (state_q == ST_UP_SUPPLY) || (state_q == ST_UP_SETTLE);
    assign wait_limit = (state_q == ST_UP_SUPPLY) ? LIM_SUPPLY : LIM_SETTLE;

    cms_settle_timer #(.MAX_TICKS(MAX_TICKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (wait_run),
        .tick  (ref_tick),
        .limit (wait_limit),
        .done  (wait_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLOW:      if (dec.cmd == CMD_GO_FAST) state_d = ST_UP_SUPPLY;
            ST_UP_SUPPLY: if (wait_done)              state_d = ST_UP_SETTLE;
            ST_UP_SETTLE: if (wait_done)              state_d = ST_FAST;
            ST_FAST:      if (dec.cmd == CMD_GO_SLOW) state_d = ST_DN_SEL;
            ST_DN_SEL:                                state_d = ST_DN_OSC;
            ST_DN_OSC:                                state_d = ST_SLOW;
            default:                                  state_d = ST_SLOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SLOW;
        else     state_q <= state_d;
    end

    assign drv          = drive_of(state_q);
    assign supply_hs    = drv.supply_hs;
    assign fast_osc_en  = drv.osc_en;
    assign clk_sel_fast = drv.sel_fast;
    assign busy         = drv.busy;

    always_comb begin
        err_set              = '0;
        err_set[ERR_OVERLAP] = dec.overlap;
        err_set[ERR_REFUSED] = dec.refused;
    end

    cms_err_reg #(.W(ERR_W)) u_err (
        .clk (clk),
        .rst (rst),
        .set (err_set),
        .clr (err_clr),
        .q   (err_status)
    );

    cms_halt_gate u_halt (
        .clk          (clk),
        .rst          (rst),
        .halt_req     (halt_req),
        .slow_idle    (state_q == ST_SLOW),
        .halt_out     (halt_out),
        .halt_blocked (halt_blocked)
    );
endmodule

// File: rtl/clk_mode_seq_chk.sv
module clk_mode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_fast,
    input logic       req_slow,
    input logic       halver_mode,
    input logic [1:0] err_clr,
    input logic       supply_hs,
    input logic       fast_osc_en,
    input logic       clk_sel_fast,
    input logic       busy,
    input logic [1:0] err_status,
    input logic       halt_out,
    input logic       halt_blocked
);
    AST_OSC_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        fast_osc_en |-> supply_hs); // R5

    AST_SEL_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        clk_sel_fast |-> fast_osc_en); // R3

    AST_NO_JOINT_FALL: assert property (@(posedge clk) disable iff (rst)
        !($fell(clk_sel_fast) && $fell(fast_osc_en))); // R4

    AST_OSC_OFF_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_sel_fast) |=> $fell(fast_osc_en)); // R4

    AST_SUPPLY_DROP_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(supply_hs) |-> (!fast_osc_en && !clk_sel_fast && $past(!fast_osc_en))); // R5

    AST_HALT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(halt_out && halt_blocked)); // R7

    AST_HALT_NOT_ON_FAST: assert property (@(posedge clk) disable iff (rst)
        halt_out |-> !clk_sel_fast); // R7

    AST_HALVER_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (req_fast && !req_slow && halver_mode && !busy && !clk_sel_fast)
        |=> (!supply_hs && err_status[1])); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_status[0] && !err_clr[0]) |=> err_status[0]); // R10

    AST_FAST_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_sel_fast) |-> !busy); // R8
endmodule

bind clk_mode_seq clk_mode_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_fast     (req_fast),
    .req_slow     (req_slow),
    .halver_mode  (halver_mode),
    .err_clr      (err_clr),
    .supply_hs    (supply_hs),
    .fast_osc_en  (fast_osc_en),
    .clk_sel_fast (clk_sel_fast),
    .busy         (busy),
    .err_status   (err_status),
    .halt_out     (halt_out),
    .halt_blocked (halt_blocked)
);

// File: tb/clk_mode_seq_tb_top.sv
`timescale 1ns/1ps
module clk_mode_seq_tb_top;
    localparam int TV = 5;
    localparam int TO = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       req_fast = 1'b0;
    logic       req_slow = 1'b0;
    logic       halver_mode = 1'b0;
    logic       halt_req = 1'b0;
    logic [1:0] err_clr = 2'b00;
    logic       supply_hs, fast_osc_en, clk_sel_fast, busy, halt_out, halt_blocked;
    logic [1:0] err_status;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit tick_auto = 1'b1;
    int tdiv = 0;

    clk_mode_seq #(.UP_SUPPLY_TICKS(TV), .OSC_SETTLE_TICKS(TO)) dut_i (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .req_fast(req_fast),
        .req_slow(req_slow), .halver_mode(halver_mode), .halt_req(halt_req),
        .err_clr(err_clr), .supply_hs(supply_hs), .fast_osc_en(fast_osc_en),
        .clk_sel_fast(clk_sel_fast), .busy(busy), .err_status(err_status),
        .halt_out(halt_out), .halt_blocked(halt_blocked)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // reference tick source
    always @(negedge clk) begin
        ref_tick = tick_auto && (tdiv == 2);
        tdiv = (tdiv + 1) % 3;
    end

    // behavioural reference: phase 0 slow,1 supply wait,2 osc wait,3 fast,4 sel down,5 osc down
    int m_phase = 0;
    int m_ticks = 0;
    bit [1:0] m_err = 0;
    bit m_hout = 0, m_hblk = 0;

    always @(posedge clk) begin
        bit s0, s1, idle;
        cycles++;
        if (rst) begin
            m_phase = 0; m_ticks = 0; m_err = 0; m_hout = 0; m_hblk = 0;
        end else begin
            s0 = 0; s1 = 0;
            idle = (m_phase == 0) || (m_phase == 3);
            m_hout = halt_req && (m_phase == 0);
            m_hblk = halt_req && (m_phase != 0);
            if (!idle) begin
                if (req_fast || req_slow) s0 = 1;
                if (m_phase == 1 || m_phase == 2) begin
                    if (ref_tick) m_ticks++;
                    if (m_ticks == ((m_phase == 1) ? TV : TO)) begin
                        m_phase++; m_ticks = 0;
                    end
                end else if (m_phase == 4) m_phase = 5;
                else m_phase = 0;
            end else if (req_fast && req_slow) s0 = 1;
            else if (m_phase == 0 && req_fast) begin
                if (halver_mode) s1 = 1;
                else begin m_phase = 1; m_ticks = 0; end
            end else if (m_phase == 3 && req_slow) m_phase = 4;
            m_err = (m_err & ~err_clr) | {s1, s0};
        end
        #1;
        if (!rst) begin
            check(supply_hs == (m_phase != 0), "R2/R5 supply_hs", supply_hs, m_phase != 0);
            check(fast_osc_en == (m_phase == 2 || m_phase == 3 || m_phase == 4),
                  "R3/R4 fast_osc_en", fast_osc_en, (m_phase == 2 || m_phase == 3 || m_phase == 4));
            check(clk_sel_fast == (m_phase == 3), "R3/R4 clk_sel_fast", clk_sel_fast, m_phase == 3);
            check(busy == !(m_phase == 0 || m_phase == 3), "R8 busy", busy, !(m_phase == 0 || m_phase == 3));
            check(err_status == m_err, "R9/R10 err_status", err_status, m_err);
            check({halt_out, halt_blocked} == {m_hout, m_hblk}, "R7 halt",
                  {halt_out, halt_blocked}, {m_hout, m_hblk});
        end
        if (cycles > 100000) begin
            check(0, "watchdog", cycles, 100000);
            report();
        end
    end

    task automatic pulse(input bit f, input bit s);
        @(negedge clk); req_fast = f; req_slow = s;
        @(negedge clk); req_fast = 0; req_slow = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        int tk;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check({supply_hs, fast_osc_en, clk_sel_fast, busy, err_status, halt_out, halt_blocked} == 0,
              "R1", {supply_hs, fast_osc_en, clk_sel_fast, busy, err_status, halt_out, halt_blocked}, 0);

        // R11 slow request while slow
        pulse(0, 1); @(negedge clk);
        check({supply_hs, busy, err_status} == 0, "R11", {supply_hs, busy, err_status}, 0);

        // R7 halt passes while idle slow
        halt_req = 1; @(negedge clk); halt_req = 0;
        check(halt_out == 1 && halt_blocked == 0, "R7 pass", {halt_out, halt_blocked}, 2);

        // R6 halver refusal
        halver_mode = 1; pulse(1, 0); repeat (3) @(negedge clk);
        check(supply_hs == 0 && busy == 0, "R6 stay slow", supply_hs, 0);
        check(err_status == 2'b10, "R6 err", err_status, 2);
        halver_mode = 0;

        // R10 clear
        err_clr = 2'b10; @(negedge clk); err_clr = 0;
        check(err_status == 0, "R10 clear", err_status, 0);

        // R9 conflicting requests while idle
        pulse(1, 1);
        check(err_status == 2'b01 && supply_hs == 0, "R9 conflict", err_status, 1);
        err_clr = 2'b01; @(negedge clk); err_clr = 0;

        // R2/R3 tick counting through an up-sequence
        pulse(1, 0);
        check(supply_hs == 1 && busy == 1 && fast_osc_en == 0, "R2 supply first", supply_hs, 1);
        tk = 0;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk); if (ref_tick) tk++;
            #1; if (fast_osc_en) break;
        end
        check(tk == TV, "R2 supply ticks", tk, TV);
        tk = 0;
        for (int i = 0; i < 1000; i++) begin
            @(posedge clk); if (ref_tick) tk++;
            #1; if (clk_sel_fast) break;
        end
        check(tk == TO, "R3 settle ticks", tk, TO);
        check(busy == 0, "R3 busy low on fast", busy, 0);

        // R11 fast request while fast; R7 halt blocked on fast
        @(negedge clk);
        pulse(1, 0);
        check(err_status == 0 && clk_sel_fast == 1, "R11 fast", err_status, 0);
        halt_req = 1; @(negedge clk); halt_req = 0;
        check(halt_out == 0 && halt_blocked == 1, "R7 block", {halt_out, halt_blocked}, 1);

        // R4/R5 teardown order
        pulse(0, 1);
        check(clk_sel_fast == 0 && fast_osc_en == 1, "R4 sel first", fast_osc_en, 1);
        @(negedge clk);
        check(fast_osc_en == 0 && supply_hs == 1, "R4 osc second", supply_hs, 1);
        @(negedge clk);
        check(supply_hs == 0 && busy == 0, "R5 supply last", supply_hs, 0);

        // R12 ticks stopped mid-wait; R9 busy request with R10 set-wins clear
        pulse(1, 0);
        tick_auto = 0;
        repeat (40) @(negedge clk);
        check(fast_osc_en == 0 && supply_hs == 1 && busy == 1, "R12 hold", fast_osc_en, 0);
        err_clr = 2'b01; req_slow = 1; @(negedge clk); req_slow = 0; err_clr = 0;
        check(err_status[0] == 1, "R10 set wins", err_status[0], 1);
        check(supply_hs == 1 && busy == 1, "R9 ignored", busy, 1);
        halt_req = 1; @(negedge clk); halt_req = 0;
        check(halt_blocked == 1, "R7 block busy", halt_blocked, 1);
        tick_auto = 1;
        wait_idle();
        check(clk_sel_fast == 1, "R3 reach fast", clk_sel_fast, 1);
        pulse(0, 1); wait_idle();
        check(supply_hs == 0 && clk_sel_fast == 0, "R5 back slow", supply_hs, 0);
        repeat (4) @(negedge clk);
        report();
    end
endmodule